// File: doc/BRIEF.md
# Host/Local Mailbox and Doorbell Interrupt Unit

This block passes short messages and doorbell events between a host-side bus master and a local processor. Each side owns a simple register port (request, write enable, word address, write data) and receives its own interrupt line. The host deposits words into two inbound message registers and rings inbound doorbell bits. The local processor deposits words into two outbound message registers and rings outbound doorbell bits. Each of these events raises a status bit on the opposite side.

Each side has a status word and a mask. The status word collects message arrivals, doorbell activity, queue events reported by an external queue engine and, on the local side, a machine-check alert raised by the host. Reading a doorbell or a status word returns its value and clears it in the same access. The status value returned is gated by that side's mask, and the interrupt line is the OR of every unmasked status bit.

Word addresses (both ports): 0/1 inbound message 0/1, 2/3 outbound message 0/1, 4 inbound doorbell, 5 outbound doorbell, 6 own status word, 7 own mask, 8 machine-check raise (host write only). An access to an address that the side does not own is ignored on write and returns zero on read.

Top module: `msg_db_unit`

## Requirements
- R1: After reset all message, doorbell and status registers are zero, the host mask reads 0x02B, the local mask reads 0x1BB (every source masked), and both interrupt lines are low.
- R2: A host write to address 0 or 1 is read back by the local side at the same address; a local write to address 2 or 3 is read back by the host at the same address. Read data is presented one clock after the read request is taken.
- R3: A host write to inbound message 0 or 1 sets local status bit 0 or 1; a local write to outbound message 0 or 1 sets host status bit 0 or 1.
- R4: A doorbell write (host to address 4, local to address 5) ORs its data into the doorbell register; a read by the owning peer (local at 4, host at 5) returns the contents and clears the register.
- R5: Status bit 3 of a side reads 1 exactly while that side's incoming doorbell register is nonzero.
- R6: A host write to address 8 with data bit 0 set raises local status bit 4 (machine check) and leaves the inbound doorbell register unchanged.
- R7: Queue event inputs set sticky status bits: out_q_evt sets host bit 5; in_q_evt bits 0, 1, 2 set local bits 5, 7, 8.
- R8: A status read (address 6) returns the status ANDed with the inverted mask, with all bits other than the defined ones zero (host defined bits 0,1,3,5; local 0,1,3,4,5,7,8), and clears every sticky status bit, masked or not.
- R9: Each interrupt line is high exactly when some defined status bit of that side is 1 while its mask bit is 0.
- R10: When a clearing read and a new set event hit a doorbell or a status bit in the same clock, the new event is kept.
- R11: A mask write (address 7) stores only the defined bits of that side; the rest read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write enable |
| h_addr | input | 4 | Host word address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one clock after request |
| l_req | input | 1 | Local access request |
| l_we | input | 1 | Local write enable |
| l_addr | input | 4 | Local word address |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data, one clock after request |
| in_q_evt | input | 3 | Inbound queue event pulses (post, post overflow, free overflow) |
| out_q_evt | input | 1 | Outbound post queue event pulse |
| host_irq | output | 1 | Host interrupt |
| local_irq | output | 1 | Local interrupt |

## Verification
Writes, doorbell rings, queue pulses and clearing reads all take effect at the clock edge that takes the request, so status, doorbell contents and both interrupt lines are due just after that edge; read data is registered at the same edge and is due at the same time. The bench drives each request shortly after one rising edge and samples everything 2 ns after the next, comparing against a model whose expected read values are taken from its state before it applies that cycle's clears and sets. Same-cycle read-and-set collisions are forced directly, and random traffic on both ports exercises masks and clears together.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int SW = 9;
    localparam int NMSG = 2;

    typedef enum logic [AW-1:0] {
        A_IMSG0 = 4'd0,
        A_IMSG1 = 4'd1,
        A_OMSG0 = 4'd2,
        A_OMSG1 = 4'd3,
        A_IDB   = 4'd4,
        A_ODB   = 4'd5,
        A_STAT  = 4'd6,
        A_MASK  = 4'd7,
        A_MCHK  = 4'd8
    } reg_addr_e;

    localparam int B_MSG0 = 0;
    localparam int B_MSG1 = 1;
    localparam int B_DB   = 3;
    localparam int B_MC   = 4;
    localparam int B_PQ   = 5;
    localparam int B_PQOV = 7;
    localparam int B_FQOV = 8;

    localparam logic [SW-1:0] OUT_VALID  = 9'h02B;
    localparam logic [SW-1:0] OUT_STICKY = 9'h023;
    localparam logic [SW-1:0] IN_VALID   = 9'h1BB;
    localparam logic [SW-1:0] IN_STICKY  = 9'h1B3;
endpackage

// File: rtl/mdu_mailbox.sv
module mdu_mailbox #(
    parameter int DW = 32,
    parameter int N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      wr_en,
    input  logic [DW-1:0]     wdata,
    output logic [N-1:0][DW-1:0] msg
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)        msg[i] <= '0;
            else if (wr_en[i]) msg[i] <= wdata;
        end
    end
endmodule

// File: rtl/mdu_doorbell.sv
module mdu_doorbell #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ring,
    input  logic [DW-1:0] ring_bits,
    input  logic          rd_clr,
    output logic [DW-1:0] db_q,
    output logic          nonzero
);
    logic [DW-1:0] kept;
    logic [DW-1:0] added;

    always_comb begin
        kept    = rd_clr ? '0 : db_q;
        added   = ring ? ring_bits : '0;
        nonzero = |db_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) db_q <= '0;
        else        db_q <= kept | added;
    end
endmodule

// File: rtl/mdu_stat.sv
module mdu_stat #(
    parameter int              SW       = 9,
    parameter logic [SW-1:0]   VALID    = '1,
    parameter logic [SW-1:0]   STICKY   = '1,
    parameter int              LIVE_BIT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] set_ev,
    input  logic          live,
    input  logic          rd_clr,
    input  logic          mask_we,
    input  logic [SW-1:0] mask_wd,
    output logic [SW-1:0] sticky_q,
    output logic [SW-1:0] mask_q,
    output logic [SW-1:0] view,
    output logic          irq
);
    logic [SW-1:0] live_vec;
    logic [SW-1:0] raw;

    always_comb begin
        live_vec = '0;
        live_vec[LIVE_BIT] = live;
        raw  = sticky_q | live_vec;
        view = raw & ~mask_q & VALID;
        irq  = |view;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
            mask_q   <= VALID;
        end else begin
            sticky_q <= ((rd_clr ? '0 : sticky_q) | set_ev) & STICKY;
            if (mask_we) mask_q <= mask_wd & VALID;
        end
    end
endmodule

// File: rtl/msg_db_unit.sv
module msg_db_unit
    import mdu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_req,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic          l_req,
    input  logic          l_we,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    input  logic [2:0]    in_q_evt,
    input  logic          out_q_evt,
    output logic          host_irq,
    output logic          local_irq
);
    logic h_wr, h_rd, l_wr, l_rd;
    logic [NMSG-1:0] in_msg_we, out_msg_we;
    logic [NMSG-1:0][DW-1:0] in_msg, out_msg;
    logic in_ring, out_ring, in_db_clr, out_db_clr;
    logic [DW-1:0] in_db_q, out_db_q;
    logic in_db_nz, out_db_nz;
    logic in_stat_clr, out_stat_clr, in_mask_we, out_mask_we;
    logic [SW-1:0] in_set, out_set;
    logic [SW-1:0] in_sticky_q, out_sticky_q, in_mask_q, out_mask_q, in_view, out_view;
    logic [DW-1:0] h_mux, l_mux;

    always_comb begin
        h_wr = h_req & h_we;
        h_rd = h_req & ~h_we;
        l_wr = l_req & l_we;
        l_rd = l_req & ~l_we;

        in_msg_we[0]  = h_wr && (h_addr == A_IMSG0);
        in_msg_we[1]  = h_wr && (h_addr == A_IMSG1);
        out_msg_we[0] = l_wr && (l_addr == A_OMSG0);
        out_msg_we[1] = l_wr && (l_addr == A_OMSG1);
        in_ring       = h_wr && (h_addr == A_IDB);
        out_ring      = l_wr && (l_addr == A_ODB);
        in_db_clr     = l_rd && (l_addr == A_IDB);
        out_db_clr    = h_rd && (h_addr == A_ODB);
        in_stat_clr   = l_rd && (l_addr == A_STAT);
        out_stat_clr  = h_rd && (h_addr == A_STAT);
        in_mask_we    = l_wr && (l_addr == A_MASK);
        out_mask_we   = h_wr && (h_addr == A_MASK);

        in_set          = '0;
        in_set[B_MSG0]  = in_msg_we[0];
        in_set[B_MSG1]  = in_msg_we[1];
        in_set[B_MC]    = h_wr && (h_addr == A_MCHK) && h_wdata[0];
        in_set[B_PQ]    = in_q_evt[0];
        in_set[B_PQOV]  = in_q_evt[1];
        in_set[B_FQOV]  = in_q_evt[2];

        out_set         = '0;
        out_set[B_MSG0] = out_msg_we[0];
        out_set[B_MSG1] = out_msg_we[1];
        out_set[B_PQ]   = out_q_evt;
    end

    mdu_mailbox #(.DW(DW), .N(NMSG)) u_in_mbox (
        .clk(clk), .rst_n(rst_n), .wr_en(in_msg_we), .wdata(h_wdata), .msg(in_msg)
    );
    mdu_mailbox #(.DW(DW), .N(NMSG)) u_out_mbox (
        .clk(clk), .rst_n(rst_n), .wr_en(out_msg_we), .wdata(l_wdata), .msg(out_msg)
    );

    mdu_doorbell #(.DW(DW)) u_in_db (
        .clk(clk), .rst_n(rst_n), .ring(in_ring), .ring_bits(h_wdata),
        .rd_clr(in_db_clr), .db_q(in_db_q), .nonzero(in_db_nz)
    );
    mdu_doorbell #(.DW(DW)) u_out_db (
        .clk(clk), .rst_n(rst_n), .ring(out_ring), .ring_bits(l_wdata),
        .rd_clr(out_db_clr), .db_q(out_db_q), .nonzero(out_db_nz)
    );

    mdu_stat #(.SW(SW), .VALID(IN_VALID), .STICKY(IN_STICKY), .LIVE_BIT(B_DB)) u_in_stat (
        .clk(clk), .rst_n(rst_n), .set_ev(in_set), .live(in_db_nz), .rd_clr(in_stat_clr),
        .mask_we(in_mask_we), .mask_wd(l_wdata[SW-1:0]), .sticky_q(in_sticky_q),
        .mask_q(in_mask_q), .view(in_view), .irq(local_irq)
    );
    mdu_stat #(.SW(SW), .VALID(OUT_VALID), .STICKY(OUT_STICKY), .LIVE_BIT(B_DB)) u_out_stat (
        .clk(clk), .rst_n(rst_n), .set_ev(out_set), .live(out_db_nz), .rd_clr(out_stat_clr),
        .mask_we(out_mask_we), .mask_wd(h_wdata[SW-1:0]), .sticky_q(out_sticky_q),
        .mask_q(out_mask_q), .view(out_view), .irq(host_irq)
    );

    always_comb begin
        unique case (h_addr)
            A_OMSG0: h_mux = out_msg[0];
            A_OMSG1: h_mux = out_msg[1];
            A_ODB:   h_mux = out_db_q;
            A_STAT:  h_mux = DW'(out_view);
            A_MASK:  h_mux = DW'(out_mask_q);
            default: h_mux = '0;
        endcase
        unique case (l_addr)
            A_IMSG0: l_mux = in_msg[0];
            A_IMSG1: l_mux = in_msg[1];
            A_IDB:   l_mux = in_db_q;
            A_STAT:  l_mux = DW'(in_view);
            A_MASK:  l_mux = DW'(in_mask_q);
            default: l_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rdata <= '0;
            l_rdata <= '0;
        end else begin
            if (h_rd) h_rdata <= h_mux;
            if (l_rd) l_rdata <= l_mux;
        end
    end
endmodule

// File: rtl/mdu_chk.sv
module mdu_chk
    import mdu_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          h_req,
    input logic          h_we,
    input logic [AW-1:0] h_addr,
    input logic [DW-1:0] h_wdata,
    input logic          l_req,
    input logic          l_we,
    input logic [AW-1:0] l_addr,
    input logic [2:0]    in_q_evt,
    input logic          local_irq,
    input logic [DW-1:0] in_db,
    input logic [SW-1:0] in_sticky,
    input logic [SW-1:0] in_mask
);
    logic l_db_rd, h_db_wr, l_st_rd;
    always_comb begin
        l_db_rd = l_req && !l_we && (l_addr == A_IDB);
        h_db_wr = h_req && h_we && (h_addr == A_IDB);
        l_st_rd = l_req && !l_we && (l_addr == A_STAT);
    end

    a_r4_db_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (l_db_rd && !h_db_wr) |=> (in_db == '0));

    a_r10_db_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (l_db_rd && h_db_wr && (h_wdata != '0)) |=> (in_db != '0));

    a_r3_msg_sets_stat: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && h_we && (h_addr == A_IMSG0)) |=> in_sticky[B_MSG0]);

    a_r8_stat_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (l_st_rd && !h_req && (in_q_evt == 3'b000)) |=> (in_sticky == '0));

    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_mask & IN_VALID) == IN_VALID) |-> !local_irq);
endmodule

bind msg_db_unit mdu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .l_req(l_req), .l_we(l_we), .l_addr(l_addr),
    .in_q_evt(in_q_evt), .local_irq(local_irq), .in_db(in_db_q),
    .in_sticky(in_sticky_q), .in_mask(in_mask_q)
);

// File: tb/msg_db_unit_tb.sv
module msg_db_unit_tb;
    localparam logic [8:0] OV = 9'h02B;
    localparam logic [8:0] IV = 9'h1BB;
    localparam logic [8:0] OS = 9'h023;
    localparam logic [8:0] IS = 9'h1B3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_req = 0, h_we = 0, l_req = 0, l_we = 0, out_q_evt = 0;
    logic [3:0] h_addr = 0, l_addr = 0;
    logic [31:0] h_wdata = 0, l_wdata = 0;
    logic [2:0] in_q_evt = 0;
    logic [31:0] h_rdata, l_rdata;
    logic host_irq, local_irq;

    int nchk = 0;
    int nfail = 0;

    logic [31:0] m_im [2];
    logic [31:0] m_om [2];
    logic [31:0] m_idb, m_odb;
    logic [8:0] m_ist, m_ost, m_imask, m_omask;

    always #5 clk = ~clk;

    msg_db_unit u_dut (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .l_req(l_req), .l_we(l_we),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .in_q_evt(in_q_evt), .out_q_evt(out_q_evt),
        .host_irq(host_irq), .local_irq(local_irq)
    );

    function automatic logic [31:0] host_view();
        logic [8:0] r = m_ost | ((m_odb != 0) ? 9'h008 : 9'h000);
        return 32'(r & ~m_omask & OV);
    endfunction

    function automatic logic [31:0] local_view();
        logic [8:0] r = m_ist | ((m_idb != 0) ? 9'h008 : 9'h000);
        return 32'(r & ~m_imask & IV);
    endfunction

    function automatic logic [31:0] exp_hread(logic [3:0] a);
        case (a)
            4'd2: return m_om[0];
            4'd3: return m_om[1];
            4'd5: return m_odb;
            4'd6: return host_view();
            4'd7: return 32'(m_omask);
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] exp_lread(logic [3:0] a);
        case (a)
            4'd0: return m_im[0];
            4'd1: return m_im[1];
            4'd4: return m_idb;
            4'd6: return local_view();
            4'd7: return 32'(m_imask);
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] a);
        case (a)
            4'd0, 4'd1, 4'd2, 4'd3: return "R2";
            4'd4, 4'd5: return "R4";
            4'd6: return "R8";
            4'd7: return "R11";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic model_reset();
        m_im[0] = 0; m_im[1] = 0; m_om[0] = 0; m_om[1] = 0;
        m_idb = 0; m_odb = 0; m_ist = 0; m_ost = 0;
        m_imask = IV; m_omask = OV;
    endtask

    task automatic step(input logic hr, input logic hw, input logic [3:0] ha, input logic [31:0] hd,
                        input logic lr, input logic lw, input logic [3:0] la, input logic [31:0] ld,
                        input logic [2:0] iq, input logic oq, input string tag);
        logic [31:0] eh, el;
        h_req = hr; h_we = hw; h_addr = ha; h_wdata = hd;
        l_req = lr; l_we = lw; l_addr = la; l_wdata = ld;
        in_q_evt = iq; out_q_evt = oq;
        eh = exp_hread(ha);
        el = exp_lread(la);
        // clears first, then sets: a new event survives a same-cycle clear (R10)
        if (lr && !lw && la == 4'd4) m_idb = 0;
        if (hr && !hw && ha == 4'd5) m_odb = 0;
        if (lr && !lw && la == 4'd6) m_ist = 0;
        if (hr && !hw && ha == 4'd6) m_ost = 0;
        if (hr && hw) begin
            case (ha)
                4'd0: begin m_im[0] = hd; m_ist[0] = 1'b1; end
                4'd1: begin m_im[1] = hd; m_ist[1] = 1'b1; end
                4'd4: m_idb = m_idb | hd;
                4'd7: m_omask = hd[8:0] & OV;
                4'd8: if (hd[0]) m_ist[4] = 1'b1;
                default: ;
            endcase
        end
        if (lr && lw) begin
            case (la)
                4'd2: begin m_om[0] = ld; m_ost[0] = 1'b1; end
                4'd3: begin m_om[1] = ld; m_ost[1] = 1'b1; end
                4'd5: m_odb = m_odb | ld;
                4'd7: m_imask = ld[8:0] & IV;
                default: ;
            endcase
        end
        if (iq[0]) m_ist[5] = 1'b1;
        if (iq[1]) m_ist[7] = 1'b1;
        if (iq[2]) m_ist[8] = 1'b1;
        if (oq) m_ost[5] = 1'b1;
        m_ist = m_ist & IS;
        m_ost = m_ost & OS;
        @(posedge clk);
        #2;
        if (hr && !hw) chk((tag != "") ? tag : tag_of(ha), h_rdata, eh);
        if (lr && !lw) chk((tag != "") ? tag : tag_of(la), l_rdata, el);
        chk("R9 host_irq", 32'(host_irq), 32'(host_view() != 0));
        chk("R9 local_irq", 32'(local_irq), 32'(local_view() != 0));
        h_req = 0; l_req = 0; in_q_evt = 0; out_q_evt = 0;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 3'b000, 1'b0, "");
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        chk("R1 host_irq", 32'(host_irq), 32'd0);
        chk("R1 local_irq", 32'(local_irq), 32'd0);
        step(1, 0, 4'd7, 0, 1, 0, 4'd7, 0, 3'b000, 0, "R1");
        step(1, 0, 4'd6, 0, 1, 0, 4'd4, 0, 3'b000, 0, "R1");

        // R11: only defined mask bits stored; unmask everything
        step(1, 1, 4'd7, 32'hFFFF_FE00, 1, 1, 4'd7, 32'h0000_0E44, 3'b000, 0, "");
        step(1, 0, 4'd7, 0, 1, 0, 4'd7, 0, 3'b000, 0, "R11");
        step(1, 1, 4'd7, 32'h0, 1, 1, 4'd7, 32'h0, 3'b000, 0, "");

        // R2 / R3: message transfer and status
        step(1, 1, 4'd1, 32'hCAFE_0001, 1, 1, 4'd2, 32'hBEEF_0002, 3'b000, 0, "");
        step(1, 0, 4'd2, 0, 1, 0, 4'd1, 0, 3'b000, 0, "R2");
        step(1, 0, 4'd6, 0, 1, 0, 4'd6, 0, 3'b000, 0, "R3");
        step(1, 0, 4'd6, 0, 1, 0, 4'd6, 0, 3'b000, 0, "R8");

        // R4 / R5: doorbell OR, live status bit, clear on read
        step(1, 1, 4'd4, 32'h0000_0005, 1, 1, 4'd5, 32'h8000_0000, 3'b000, 0, "");
        step(1, 1, 4'd4, 32'h0000_0100, 0, 0, 0, 0, 3'b000, 0, "");
        step(1, 0, 4'd6, 0, 1, 0, 4'd6, 0, 3'b000, 0, "R5");
        step(1, 0, 4'd5, 0, 1, 0, 4'd4, 0, 3'b000, 0, "R4");
        step(1, 0, 4'd5, 0, 1, 0, 4'd4, 0, 3'b000, 0, "R4");

        // R10: ring and clear in the same cycle
        step(1, 1, 4'd4, 32'h0000_0080, 1, 0, 4'd4, 0, 3'b000, 0, "R10");
        step(0, 0, 0, 0, 1, 0, 4'd4, 0, 3'b000, 0, "R10");
        step(1, 1, 4'd0, 32'h1, 1, 0, 4'd6, 0, 3'b000, 0, "R10");
        step(0, 0, 0, 0, 1, 0, 4'd6, 0, 3'b000, 0, "R10");

        // R6: machine check separate from doorbell
        step(1, 1, 4'd8, 32'h1, 0, 0, 0, 0, 3'b000, 0, "");
        step(0, 0, 0, 0, 1, 0, 4'd4, 0, 3'b000, 0, "R6");
        step(0, 0, 0, 0, 1, 0, 4'd6, 0, 3'b000, 0, "R6");

        // R7: queue events
        step(0, 0, 0, 0, 0, 0, 0, 0, 3'b111, 1, "");
        step(1, 0, 4'd6, 0, 1, 0, 4'd6, 0, 3'b000, 0, "R7");

        // R8 / R9: masked view and masked clear
        step(0, 0, 0, 0, 1, 1, 4'd7, 32'h0000_01A0, 3'b011, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 0, 3'b100, 0, "");
        step(0, 0, 0, 0, 1, 0, 4'd6, 0, 3'b000, 0, "R8");
        step(0, 0, 0, 0, 1, 1, 4'd7, 32'h0, 3'b000, 0, "");
        step(0, 0, 0, 0, 1, 0, 4'd6, 0, 3'b000, 0, "R8");

        // random traffic on both ports
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] ha, la;
            logic [31:0] hd, ld;
            ha = 4'($urandom_range(0, 9));
            la = 4'($urandom_range(0, 9));
            hd = $urandom();
            ld = $urandom();
            if ($urandom_range(0, 3) != 0) hd = hd & 32'h0000_01FF;
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ha, hd,
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), la, ld,
                 ($urandom_range(0, 7) == 0) ? 3'($urandom()) : 3'b000,
                 ($urandom_range(0, 7) == 0), "");
        end
        idle();
        finish_run();
    end
endmodule